// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block sits beside a small 8-bit processor core and combines five hardware interrupt request lines into a single request toward the core. The five lines are a non-maskable trap, three restart lines that each branch to a fixed address, and one general request. The general request gets its vector from an external device. A fixed priority picks the winning line. The block presents a request flag and a 16-bit vector address for the winner. When the winning line is the general request, it raises a flag instead, which tells the core to read the vector from the external bus.

The three restart lines differ in how they are sensed. The highest one captures a rising edge and holds it until it is serviced or cleared. The other two follow the pin level. The trap needs a rising edge and must then stay high. The core controls the block through a single write port, which loads the three restart mask bits and the global enable and can also discard a captured restart edge. The core services an interrupt by pulsing acknowledge. This clears the captured state of the line granted in that cycle. If that line is maskable, the global enable also drops.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset no request is presented, the global enable is 0 and all three restart mask bits are 1 (blocked). In this state only the trap can be presented.
- R2: Priority from highest to lowest is: trap, srcRst[2], srcRst[1], srcRst[0], general. The vectors are 0x0024 for the trap, 0x003C for srcRst[2], 0x0034 for srcRst[1] and 0x002C for srcRst[0].
- R3: The trap is armed by a rising edge on srcTrap, one clock later. It is presented only while armed and srcTrap is still high. A low srcTrap disarms it. The trap ignores the masks and the global enable.
- R4: A rising edge on srcRst[2] is captured and stays pending after the pin falls, including while the line is masked or disabled. It is presented once it is unmasked and enabled.
- R5: srcRst[1] and srcRst[0] are level-sensitive. Each is presented in the same cycle its pin is high and withdrawn in the same cycle its pin falls.
- R6: A write (cfgWrite=1) loads cfgMask and cfgEnable. cfgMask bit 2 blocks srcRst[2], bit 1 blocks srcRst[1] and bit 0 blocks srcRst[0]. A blocked line is never granted.
- R7: While the global enable is 0, no restart line and no general request is presented.
- R8: Acknowledging a granted maskable line (any restart line or the general request) clears the global enable. A write in the same cycle takes precedence and sets the written value.
- R9: Acknowledge clears only the latched state of the line granted in that cycle. A trap acknowledge leaves a pending srcRst[2] edge presented. An acknowledged trap with the pin still high needs a fresh edge.
- R10: A write with cfgClearEdge=1 discards a pending srcRst[2] edge. A rising edge in the same cycle as that write is kept.
- R11: When the general request wins, irqExtVector is 1 and irqVector is 0x0000. For every other winner, irqExtVector is 0.
- R12: An acknowledge while no request is presented changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| srcTrap | input | 1 | Non-maskable trap request pin |
| srcRst | input | 3 | Restart request pins; bit 2 edge-captured, bits 1 and 0 level |
| srcGeneral | input | 1 | General request pin, vector supplied externally |
| cfgWrite | input | 1 | Write strobe for mask, enable and edge clear |
| cfgMask | input | 3 | Restart mask bits, 1 blocks the line |
| cfgEnable | input | 1 | Global enable value to load |
| cfgClearEdge | input | 1 | With cfgWrite, discards the pending srcRst[2] edge |
| intAck | input | 1 | Interrupt acknowledge strobe from the core |
| irqReq | output | 1 | Interrupt request to the core |
| irqVector | output | 16 | Vector address of the winning line |
| irqExtVector | output | 1 | Winner is the general request; fetch the vector from the bus |

## Verification
The checks assume that intAck is pulsed only while the core sees irqReq. Even so, they tolerate a stray pulse, which must leave every latch and the enable untouched. They also assume that request pins change between clock edges, so that an edge line sees each rising edge for exactly one clock. The stimulus changes pins, writes and acknowledges only on the falling clock edge and holds each for whole cycles. It sweeps every combination of the five pins, the three mask bits and the enable from a fresh reset, acknowledging each winner. Directed sequences cover pulses, same-cycle write and acknowledge, and same-cycle clear and edge.

// File: rtl/irq_pkg.sv
package irq_pkg;
  // number of restart-style vectored lines
  localparam int RST_LINES = 3;
  // trap + restart lines + general request
  localparam int SRC_W = RST_LINES + 2;
  localparam int TRAP_BIT = SRC_W - 1;

  // strobes from control to datapath
  typedef struct packed {
    logic                 clrTrap;
    logic [RST_LINES-1:0] clrRst;
    logic                 clrEnable;
  } ctrlStrobe_t;
endpackage

// File: rtl/irq_datapath.sv
module irq_datapath
  import irq_pkg::*;
#(
  parameter int                 VEC_W      = 16,
  parameter logic [VEC_W-1:0]   VEC_BASE   = 16'h0024,
  parameter logic [VEC_W-1:0]   VEC_STEP   = 16'h0008,
  parameter logic [RST_LINES-1:0] EDGE_LINES = 3'b100
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 srcTrap,
  input  logic [RST_LINES-1:0] srcRst,
  input  logic                 srcGeneral,
  input  logic                 cfgWrite,
  input  logic [RST_LINES-1:0] cfgMask,
  input  logic                 cfgEnable,
  input  logic                 cfgClearEdge,
  input  ctrlStrobe_t          strobe,
  input  logic [SRC_W-1:0]     grant,
  output logic [SRC_W-1:0]     liveVec,
  output logic [VEC_W-1:0]     irqVector
);

  logic                 trapPrev;
  logic                 trapArmed;
  logic                 enQ;
  logic [RST_LINES-1:0] maskQ;
  logic [RST_LINES-1:0] rstLive;
  logic [VEC_W-1:0]     vecTable [RST_LINES];
  logic                 edgeClr;

  assign edgeClr = cfgWrite & cfgClearEdge;

  // trap: armed by a rising edge, held only while the pin stays high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trapPrev  <= 1'b0;
      trapArmed <= 1'b0;
    end else begin
      trapPrev  <= srcTrap;
      trapArmed <= (srcTrap & ~trapPrev) | (trapArmed & srcTrap & ~strobe.clrTrap);
    end
  end

  // mask and global enable; a write beats the acknowledge clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ <= '1;
      enQ   <= 1'b0;
    end else begin
      if (cfgWrite) maskQ <= cfgMask;
      if (cfgWrite)              enQ <= cfgEnable;
      else if (strobe.clrEnable) enQ <= 1'b0;
    end
  end

  // per-line sensing: edge-captured or level, chosen by EDGE_LINES
  for (genvar gi = 0; gi < RST_LINES; gi++) begin : gLine
    assign vecTable[gi] = VEC_BASE + VEC_STEP * VEC_W'(gi + 1);

    if (EDGE_LINES[gi]) begin : gEdge
      logic prevQ;
      logic pendQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          prevQ <= 1'b0;
          pendQ <= 1'b0;
        end else begin
          prevQ <= srcRst[gi];
          pendQ <= (srcRst[gi] & ~prevQ) |
                   (pendQ & ~strobe.clrRst[gi] & ~edgeClr);
        end
      end
      assign rstLive[gi] = pendQ & enQ & ~maskQ[gi];
    end else begin : gLevel
      assign rstLive[gi] = srcRst[gi] & enQ & ~maskQ[gi];
    end

    // R6
    masked_line_chk: assert property (@(posedge clk) disable iff (!rstN)
      (cfgWrite && cfgMask[gi]) |=> !grant[gi+1]);
  end

  assign liveVec = {trapArmed & srcTrap, rstLive, srcGeneral & enQ};

  // vector of the granted line; general request carries no vector
  always_comb begin
    irqVector = '0;
    if (grant[TRAP_BIT]) irqVector = VEC_BASE;
    for (int i = 0; i < RST_LINES; i++) begin
      if (grant[i+1]) irqVector = vecTable[i];
    end
  end

  // R8
  enable_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.clrEnable && !cfgWrite) |=> (liveVec[SRC_W-2:0] == '0));

  // R9
  trap_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clrTrap |=> !liveVec[TRAP_BIT]);

endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [SRC_W-1:0] liveVec,
  input  logic             intAck,
  output logic [SRC_W-1:0] grant,
  output logic             irqReq,
  output logic             irqExtVector,
  output ctrlStrobe_t      strobe
);

  // fixed priority: the highest bit of liveVec wins
  always_comb begin
    logic found;
    grant = '0;
    found = 1'b0;
    for (int i = SRC_W - 1; i >= 0; i--) begin
      if (liveVec[i] && !found) begin
        grant[i] = 1'b1;
        found    = 1'b1;
      end
    end
  end

  assign irqReq       = |liveVec;
  assign irqExtVector = grant[0];

  always_comb begin
    strobe.clrTrap   = intAck & grant[TRAP_BIT];
    strobe.clrRst    = intAck ? grant[RST_LINES:1] : '0;
    strobe.clrEnable = intAck & (|grant[SRC_W-2:0]);
  end

  // R2
  single_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> ($countones(grant) == 1));

  // R12
  idle_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    (intAck && !irqReq) |-> (strobe == '0));

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_pkg::*;
#(
  parameter int                   VEC_W      = 16,
  parameter logic [VEC_W-1:0]     VEC_BASE   = 16'h0024,
  parameter logic [VEC_W-1:0]     VEC_STEP   = 16'h0008,
  parameter logic [RST_LINES-1:0] EDGE_LINES = 3'b100
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 srcTrap,
  input  logic [RST_LINES-1:0] srcRst,
  input  logic                 srcGeneral,
  input  logic                 cfgWrite,
  input  logic [RST_LINES-1:0] cfgMask,
  input  logic                 cfgEnable,
  input  logic                 cfgClearEdge,
  input  logic                 intAck,
  output logic                 irqReq,
  output logic [VEC_W-1:0]     irqVector,
  output logic                 irqExtVector
);

  logic [SRC_W-1:0] liveVec;
  logic [SRC_W-1:0] grant;
  ctrlStrobe_t      strobe;

  irq_datapath #(
    .VEC_W(VEC_W), .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP), .EDGE_LINES(EDGE_LINES)
  ) i_datapath (
    .clk(clk), .rstN(rstN),
    .srcTrap(srcTrap), .srcRst(srcRst), .srcGeneral(srcGeneral),
    .cfgWrite(cfgWrite), .cfgMask(cfgMask), .cfgEnable(cfgEnable),
    .cfgClearEdge(cfgClearEdge),
    .strobe(strobe), .grant(grant),
    .liveVec(liveVec), .irqVector(irqVector)
  );

  irq_ctrl i_ctrl (
    .clk(clk), .rstN(rstN),
    .liveVec(liveVec), .intAck(intAck),
    .grant(grant), .irqReq(irqReq), .irqExtVector(irqExtVector),
    .strobe(strobe)
  );

  // R3
  trap_vec_chk: assert property (@(posedge clk) disable iff (!rstN)
    liveVec[TRAP_BIT] |-> (irqReq && !irqExtVector && irqVector == VEC_BASE));

  // R11
  ext_vec_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqExtVector |-> (irqReq && irqVector == '0));

endmodule

// File: tb/test_irq_prio_ctrl.sv
`timescale 1ns/1ps
module test_irq_prio_ctrl;
  logic        clk = 1'b0;
  logic        rstN;
  logic        srcTrap, srcGeneral, cfgWrite, cfgEnable, cfgClearEdge, intAck;
  logic [2:0]  srcRst, cfgMask;
  logic        irqReq, irqExtVector;
  logic [15:0] irqVector;
  int checks = 0;
  int failures = 0;
  logic doneFlag = 1'b0;

  always #2 clk = ~clk;

  irq_prio_ctrl i_irq_prio_ctrl (
    .clk(clk), .rstN(rstN), .srcTrap(srcTrap), .srcRst(srcRst),
    .srcGeneral(srcGeneral), .cfgWrite(cfgWrite), .cfgMask(cfgMask),
    .cfgEnable(cfgEnable), .cfgClearEdge(cfgClearEdge), .intAck(intAck),
    .irqReq(irqReq), .irqVector(irqVector), .irqExtVector(irqExtVector)
  );

  // expected {req, ext, vector} from the requirements
  function automatic logic [17:0] model(input logic t, input logic h, input logic m,
      input logic l, input logic g, input logic [2:0] mask, input logic en);
    if (t)                   return {1'b1, 1'b0, 16'h0024};
    if (h && en && !mask[2]) return {1'b1, 1'b0, 16'h0024 + 16'd8 * 16'd3};
    if (m && en && !mask[1]) return {1'b1, 1'b0, 16'h0024 + 16'd8 * 16'd2};
    if (l && en && !mask[0]) return {1'b1, 1'b0, 16'h0024 + 16'd8 * 16'd1};
    if (g && en)             return {1'b1, 1'b1, 16'h0000};
    return 18'd0;
  endfunction

  task automatic chk(input string tag, input logic [17:0] e);
    checks++;
    if (irqReq !== e[17] || (e[17] && (irqVector !== e[15:0] || irqExtVector !== e[16]))) begin
      failures++;
      $display("FAIL %s: got req=%0b ext=%0b vec=%h, expected req=%0b ext=%0b vec=%h",
               tag, irqReq, irqExtVector, irqVector, e[17], e[16], e[15:0]);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0; srcTrap = 0; srcRst = '0; srcGeneral = 0;
    cfgWrite = 0; cfgMask = '0; cfgEnable = 0; cfgClearEdge = 0; intAck = 0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic writeCfg(input logic [2:0] m, input logic en, input logic clr);
    cfgWrite = 1; cfgMask = m; cfgEnable = en; cfgClearEdge = clr;
    @(negedge clk);
    cfgWrite = 0; cfgClearEdge = 0;
  endtask

  task automatic pulseAck();
    intAck = 1;
    @(negedge clk);
    intAck = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!doneFlag) begin
      failures++;
      $display("FAIL R1 watchdog: got running, expected finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1: reset state blocks everything but the trap
    doReset();
    srcRst = 3'b011; srcGeneral = 1;
    @(negedge clk);
    chk("R1 reset masks and enable", model(0, 0, 0, 0, 0, 3'b000, 0));
    srcTrap = 1;
    @(negedge clk);
    chk("R1 trap passes after reset", model(1, 0, 0, 0, 0, 3'b111, 0));

    // R3: trap edge, hold, disarm, re-arm
    doReset();
    srcTrap = 1; @(negedge clk);
    chk("R3 trap armed", model(1, 0, 0, 0, 0, 3'b111, 0));
    srcTrap = 0; @(negedge clk);
    chk("R3 trap dropped", 18'd0);
    srcTrap = 1; @(negedge clk);
    chk("R3 trap rearmed", model(1, 0, 0, 0, 0, 3'b111, 0));
    pulseAck();
    chk("R9 trap acked, pin high", 18'd0);
    @(negedge clk);
    chk("R3 no fresh edge", 18'd0);
    srcTrap = 0;

    // R4: captured edge held while masked
    doReset();
    writeCfg(3'b100, 1, 0);
    srcRst[2] = 1; @(negedge clk);
    srcRst[2] = 0; @(negedge clk);
    chk("R4 masked edge hidden", 18'd0);
    writeCfg(3'b000, 1, 0);
    chk("R4 pending edge presented", model(0, 1, 0, 0, 0, 3'b000, 1));
    pulseAck();
    chk("R8 enable cleared by ack", 18'd0);
    writeCfg(3'b000, 1, 0);
    chk("R9 edge latch cleared by ack", 18'd0);

    // R10: explicit clear, and edge beating clear
    doReset();
    writeCfg(3'b000, 0, 0);
    srcRst[2] = 1; @(negedge clk);
    srcRst[2] = 0; @(negedge clk);
    chk("R7 disabled edge hidden", 18'd0);
    writeCfg(3'b000, 1, 1);
    chk("R10 cleared edge gone", 18'd0);
    srcRst[2] = 1;
    writeCfg(3'b000, 1, 1);
    chk("R10 same-cycle edge kept", model(0, 1, 0, 0, 0, 3'b000, 1));
    srcRst[2] = 0;

    // R12, R5, R8: stray ack, level following, write beats ack
    doReset();
    writeCfg(3'b000, 1, 0);
    pulseAck();
    srcRst[1] = 1; @(negedge clk);
    chk("R12 stray ack kept enable", model(0, 0, 1, 0, 0, 3'b000, 1));
    srcRst[1] = 0; @(negedge clk);
    chk("R5 level withdrawn", 18'd0);
    srcRst[1] = 1; @(negedge clk);
    chk("R5 level presented again", model(0, 0, 1, 0, 0, 3'b000, 1));
    intAck = 1;
    writeCfg(3'b000, 1, 0);
    intAck = 0;
    chk("R8 write beats ack", model(0, 0, 1, 0, 0, 3'b000, 1));
    pulseAck();
    chk("R8 ack alone clears enable", 18'd0);
    writeCfg(3'b000, 1, 0);
    chk("R7 enable restored", model(0, 0, 1, 0, 0, 3'b000, 1));
    srcRst[1] = 0;

    // sweep: every pin, mask and enable combination, then acknowledge
    for (int c = 0; c < 512; c++) begin
      logic [8:0]  cv;
      logic [17:0] e;
      cv = 9'(c);
      doReset();
      writeCfg(cv[7:5], cv[8], 0);
      srcTrap = cv[0]; srcRst = {cv[3], cv[2], cv[1]}; srcGeneral = cv[4];
      @(negedge clk);
      e = model(cv[0], cv[3], cv[2], cv[1], cv[4], cv[7:5], cv[8]);
      chk("R2 R6 R7 R11 sweep", e);
      if (e[17]) begin
        pulseAck();
        if (cv[0]) e = model(0, cv[3], cv[2], cv[1], cv[4], cv[7:5], cv[8]);
        else       e = 18'd0;
        chk("R8 R9 sweep after ack", e);
      end
    end

    doneFlag = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule